// File: doc/BRIEF.md
# Quad I/O Fast-Read Target with Continuous Read

This block is the target side of a serial memory for the quad input/output fast-read command. It oversamples chip-select, the serial clock and four data lines with its own system clock. It decodes the read opcode and gathers the address four bits per serial clock. It then takes a mode byte, lets the dummy clocks pass, and returns array bytes nibble by nibble over the four lines until chip-select rises. Bytes are fetched through a simple synchronous read port. The port takes a one-cycle request with an address, and the byte is valid on the next system clock.

A mode byte whose two nibbles are bitwise complements of each other arms continuous read. The next transaction then starts directly with the address, and no opcode is sent. Any other mode byte, or an incomplete one, returns the block to opcode decoding at the next transaction. A busy input from the program/erase side makes the block ignore the read. It never drives the lines and never touches the array port.

Top module: `qspi_fast_read_resp`

## Requirements
- R1: After reset, the output enable `dqOe` is 0 and no memory request is issued.
- R2: With `quadOpMode`=0, the opcode 0xEB arrives MSB first on DQ0 over 8 serial clocks. A 24-bit address then arrives over 6 clocks, MSB nibble first on DQ[3:0]. After the 2 mode-byte clocks and 4 dummy clocks, the byte at that address is returned, upper nibble first. The first nibble appears on the falling edge after the last dummy rising edge.
- R3: With `quadOpMode`=1, the opcode is taken as two nibbles over 2 serial clocks, upper nibble first, and the transaction then proceeds as in R2.
- R4: With `addrMode4`=1, the address is 32 bits over 8 clocks. With `addrMode4`=0, it is 24 bits over 6 clocks and `memAddr[31:24]` stays 0.
- R5: Data streams from consecutive byte addresses for as long as chip-select stays low. The address wraps to 0 after 0xFFFFFF in 24-bit mode and after 0xFFFFFFFF in 32-bit mode.
- R6: A mode byte with upper nibble equal to the complement of the lower nibble (e.g. 0xA5, 0x0F, 0xF0) makes the next transaction start at the address phase, without an opcode.
- R7: Any other mode byte (e.g. 0xFF, 0x00, 0x55) makes the next transaction expect an opcode again.
- R8: If `busy` is high at the serial clock that completes the address, the read is ignored. No memory request is made, `dqOe` stays 0, and the next transaction expects an opcode.
- R9: An opcode other than 0xEB is ignored. No memory request is made and `dqOe` stays 0 until chip-select rises.
- R10: A rise of chip-select in any phase ends the transaction and drops `dqOe`. A transaction aborted before its mode byte is complete leaves continuous read cleared.
- R11: `dqOe` is 1 only during the data phase. Output nibbles change only after falling serial-clock edges.
- R12: Each returned byte costs exactly one memory request, at the expected address. The first request is issued right after the address phase. Each later one is issued when the previous byte starts to go out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| dqIn | input | 4 | Data lines as seen from the bus |
| dqOut | output | 4 | Data nibble driven to the bus |
| dqOe | output | 1 | Drive enable for the data lines |
| busy | input | 1 | Program/erase/status-write in progress |
| addrMode4 | input | 1 | 1 selects 32-bit address, 0 selects 24-bit |
| quadOpMode | input | 1 | 1 receives the opcode as nibbles, 0 serially on DQ0 |
| memReq | output | 1 | Array read request, one cycle |
| memAddr | output | 32 | Array byte address for the request |
| memRdata | input | 8 | Array byte, valid one cycle after the request |

## Verification
The bench uses the default parameters: a 32-bit address, a 24-bit short address, 4 dummy clocks and a two-stage input synchronizer. Because the full 32-bit width is in place, the top-of-range wrap in both address modes can be reached from a start address a few bytes below the limit. The serial half-period is six system clocks, so the synchronizer delay plus the two-cycle array latency fits within each falling-to-rising window. The bench can therefore check every nibble just before the host's rising edge, and the continuous-read chaining, abort and busy cases follow one another in a single run.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

  localparam logic [7:0] READ_QUAD_OP = 8'hEB;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPCODE,
    PH_OPDEC,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_e;

  typedef struct packed {
    logic clear;       // transaction start: wipe collected fields
    logic shiftOp;     // take opcode bits on this rising edge
    logic quadOp;      // opcode arrives four bits per clock
    logic shiftAddr;   // take an address nibble
    logic shiftMode;   // take a mode-byte nibble
    logic issueFirst;  // fetch the byte at the received address
    logic loadHigh;    // present upper nibble of the next byte, prefetch the following one
    logic loadLow;     // present lower nibble of the current byte
    logic oeOff;       // chip-select high: release the lines
  } strobe_t;

endpackage

// File: rtl/qrd_sync.sv
module qrd_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) chain[g] <= RST_VAL;
          else       chain[g] <= din;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) chain[g] <= RST_VAL;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/qrd_ctrl.sv
module qrd_ctrl
  import qspi_rd_pkg::*;
#(
  parameter int SHORT_NIBS = 6,
  parameter int LONG_NIBS = 8,
  parameter int DUMMY_CLKS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csHigh,
  input  logic    sclkLvl,
  input  logic    busy,
  input  logic    addr4,
  input  logic    quadOp,
  input  logic    opMatch,
  input  logic    modeValid,
  output strobe_t st
);

  localparam int MAX_PH = (DUMMY_CLKS > LONG_NIBS) ?
                          ((DUMMY_CLKS > 8) ? DUMMY_CLKS : 8) :
                          ((LONG_NIBS > 8) ? LONG_NIBS : 8);
  localparam int CNT_W = $clog2(MAX_PH) + 1;

  phase_e phase;
  logic [CNT_W-1:0] cnt;
  logic sclkPrev;
  logic sclkRise;
  logic sclkFall;
  logic contFlag;
  logic gotMode;
  logic pendFirst;
  logic nibSel;
  logic [CNT_W-1:0] opLast;
  logic [CNT_W-1:0] addrLast;
  logic [CNT_W-1:0] modeLast;
  logic [CNT_W-1:0] dummyLast;

  assign sclkRise = sclkLvl & ~sclkPrev;
  assign sclkFall = ~sclkLvl & sclkPrev;

  assign opLast    = quadOp ? CNT_W'(1) : CNT_W'(7);
  assign addrLast  = addr4 ? CNT_W'(LONG_NIBS - 1) : CNT_W'(SHORT_NIBS - 1);
  assign modeLast  = CNT_W'(1);
  assign dummyLast = CNT_W'(DUMMY_CLKS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkLvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      contFlag  <= 1'b0;
      gotMode   <= 1'b0;
      pendFirst <= 1'b0;
      nibSel    <= 1'b0;
    end else if (csHigh) begin
      if (phase != PH_IDLE) begin
        contFlag <= gotMode & modeValid;
      end
      phase     <= PH_IDLE;
      cnt       <= '0;
      pendFirst <= 1'b0;
      nibSel    <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt     <= '0;
          gotMode <= 1'b0;
          nibSel  <= 1'b0;
          phase   <= contFlag ? PH_ADDR : PH_OPCODE;
        end
        PH_OPCODE: begin
          if (sclkRise) begin
            if (cnt == opLast) begin
              cnt   <= '0;
              phase <= PH_OPDEC;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_OPDEC: begin
          phase <= opMatch ? PH_ADDR : PH_IGNORE;
        end
        PH_ADDR: begin
          if (sclkRise) begin
            if (cnt == addrLast) begin
              cnt <= '0;
              if (busy) begin
                phase <= PH_IGNORE;
              end else begin
                phase     <= PH_MODE;
                pendFirst <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_MODE: begin
          pendFirst <= 1'b0;
          if (sclkRise) begin
            if (cnt == modeLast) begin
              cnt     <= '0;
              gotMode <= 1'b1;
              phase   <= PH_DUMMY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_DUMMY: begin
          if (sclkRise) begin
            if (cnt == dummyLast) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (sclkFall) nibSel <= ~nibSel;
        end
        PH_IGNORE: begin
          phase <= PH_IGNORE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    st            = '0;
    st.clear      = (phase == PH_IDLE);
    st.quadOp     = quadOp;
    st.shiftOp    = (phase == PH_OPCODE) && sclkRise && !csHigh;
    st.shiftAddr  = (phase == PH_ADDR) && sclkRise && !csHigh;
    st.shiftMode  = (phase == PH_MODE) && sclkRise && !csHigh;
    st.issueFirst = (phase == PH_MODE) && pendFirst && !csHigh;
    st.loadHigh   = (phase == PH_DATA) && sclkFall && !nibSel && !csHigh;
    st.loadLow    = (phase == PH_DATA) && sclkFall && nibSel && !csHigh;
    st.oeOff      = csHigh;
  end

  AST_CS_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (phase == PH_IDLE)); // R10

  AST_IGNORE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IGNORE) |=> (phase == PH_IGNORE || phase == PH_IDLE)); // R9

  AST_BUSY_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ADDR && sclkRise && busy && !csHigh && cnt == addrLast)
      |=> (phase == PH_IGNORE || phase == PH_IDLE)); // R8

endmodule

// File: rtl/qrd_datapath.sv
module qrd_datapath
  import qspi_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SHORT_AW = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [3:0]        dq,
  input  logic              addr4,
  input  logic [7:0]        memRdata,
  output logic              opMatch,
  output logic              modeValid,
  output logic [3:0]        dqOut,
  output logic              dqOe,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr
);

  localparam logic [ADDR_W-1:0] SHORT_MASK =
    {{(ADDR_W - SHORT_AW){1'b0}}, {SHORT_AW{1'b1}}};

  logic [BYTE_W-1:0] opByte;
  logic [BYTE_W-1:0] modeByte;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] readAddr;
  logic [ADDR_W-1:0] addrMask;
  logic [ADDR_W-1:0] startAddr;
  logic [BYTE_W-1:0] prefetch;
  logic [NIB_W-1:0]  curLow;
  logic              reqD;

  assign addrMask  = addr4 ? '1 : SHORT_MASK;
  assign startAddr = addrReg & addrMask;
  assign opMatch   = (opByte == READ_QUAD_OP);
  assign modeValid = (modeByte[7:4] == ~modeByte[3:0]);

  function automatic logic [ADDR_W-1:0] nextAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] m);
    return (a + 1'b1) & m;
  endfunction

  // collected request fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opByte   <= '0;
      modeByte <= '0;
      addrReg  <= '0;
    end else if (st.clear) begin
      opByte   <= '0;
      modeByte <= '0;
      addrReg  <= '0;
    end else begin
      if (st.shiftOp) begin
        opByte <= st.quadOp ? {opByte[3:0], dq} : {opByte[6:0], dq[0]};
      end
      if (st.shiftAddr) begin
        addrReg <= {addrReg[ADDR_W-NIB_W-1:0], dq};
      end
      if (st.shiftMode) begin
        modeByte <= {modeByte[3:0], dq};
      end
    end
  end

  // array port and prefetch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      memAddr  <= '0;
      readAddr <= '0;
      reqD     <= 1'b0;
      prefetch <= '0;
    end else begin
      reqD   <= memReq;
      memReq <= 1'b0;
      if (reqD) prefetch <= memRdata;
      if (st.issueFirst) begin
        memReq   <= 1'b1;
        memAddr  <= startAddr;
        readAddr <= nextAddr(startAddr, addrMask);
      end else if (st.loadHigh) begin
        memReq   <= 1'b1;
        memAddr  <= readAddr;
        readAddr <= nextAddr(readAddr, addrMask);
      end
    end
  end

  // output nibble path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqOut  <= '0;
      curLow <= '0;
      dqOe   <= 1'b0;
    end else begin
      if (st.loadHigh) begin
        dqOut  <= prefetch[7:4];
        curLow <= prefetch[3:0];
        dqOe   <= 1'b1;
      end else if (st.loadLow) begin
        dqOut <= curLow;
      end
      if (st.oeOff) dqOe <= 1'b0;
    end
  end

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R12

  AST_OE_STARTS_ON_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> $past(st.loadHigh)); // R11

  AST_LOW_NIBBLE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    st.loadLow |=> dqOe); // R11

  AST_SHORT_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !addr4) |-> (memAddr[ADDR_W-1:SHORT_AW] == '0)); // R4

endmodule

// File: rtl/qspi_fast_read_resp.sv
module qspi_fast_read_resp
  import qspi_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SHORT_AW = 24,
  parameter int DUMMY_CLKS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic [3:0]        dqIn,
  output logic [3:0]        dqOut,
  output logic              dqOe,
  input  logic              busy,
  input  logic              addrMode4,
  input  logic              quadOpMode,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdata
);

  localparam int SHORT_NIBS = SHORT_AW / NIB_W;
  localparam int LONG_NIBS = ADDR_W / NIB_W;
  localparam int BUS_W = 2 + NIB_W;

  logic [BUS_W-1:0] busRaw;
  logic [BUS_W-1:0] busSync;
  logic csHigh;
  logic sclkLvl;
  logic [3:0] dqSync;
  logic opMatch;
  logic modeValid;
  strobe_t st;

  assign busRaw  = {csN, sclk, dqIn};
  assign csHigh  = busSync[BUS_W-1];
  assign sclkLvl = busSync[BUS_W-2];
  assign dqSync  = busSync[NIB_W-1:0];

  qrd_sync #(
    .W(BUS_W),
    .STAGES(SYNC_STAGES),
    .RST_VAL({1'b1, {(BUS_W-1){1'b0}}})
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din (busRaw),
    .dout(busSync)
  );

  qrd_ctrl #(
    .SHORT_NIBS(SHORT_NIBS),
    .LONG_NIBS (LONG_NIBS),
    .DUMMY_CLKS(DUMMY_CLKS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .csHigh   (csHigh),
    .sclkLvl  (sclkLvl),
    .busy     (busy),
    .addr4    (addrMode4),
    .quadOp   (quadOpMode),
    .opMatch  (opMatch),
    .modeValid(modeValid),
    .st       (st)
  );

  qrd_datapath #(
    .ADDR_W  (ADDR_W),
    .SHORT_AW(SHORT_AW)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .dq       (dqSync),
    .addr4    (addrMode4),
    .memRdata (memRdata),
    .opMatch  (opMatch),
    .modeValid(modeValid),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .memReq   (memReq),
    .memAddr  (memAddr)
  );

endmodule

// File: tb/qspi_fast_read_resp_tb.sv
module qspi_fast_read_resp_tb_top;

  localparam int HP = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic [3:0] dqDrv = 4'h0;
  logic [3:0] dqOut;
  logic dqOe;
  logic busy = 1'b0;
  logic addrMode4 = 1'b0;
  logic quadOpMode = 1'b0;
  logic memReq;
  logic [31:0] memAddr;
  logic [7:0] memRdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int reqCount = 0;
  bit allowReq = 1'b0;
  bit oeWin = 1'b0;
  bit finished = 1'b0;
  logic [31:0] expNextAddr = 32'h0;
  logic [31:0] wrapMask = 32'h00FF_FFFF;

  always #2.5 clk = ~clk;

  qspi_fast_read_resp dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .dqIn(dqDrv),
    .dqOut(dqOut), .dqOe(dqOe), .busy(busy), .addrMode4(addrMode4),
    .quadOpMode(quadOpMode), .memReq(memReq), .memAddr(memAddr),
    .memRdata(memRdata)
  );

  function automatic logic [7:0] memFn(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // array model and per-clock request / enable reference
  always @(posedge clk) begin
    if (rstN) begin
      if (memReq) begin
        memRdata <= memFn(memAddr);
        reqCount++;
        checks++;
        if (!allowReq || memAddr !== expNextAddr) begin
          errors++;
          $display("FAIL R12 request: actual=%0h expected=%0h allowed=%0d",
                   memAddr, expNextAddr, allowReq);
        end
        expNextAddr = (expNextAddr + 32'd1) & wrapMask;
      end
      checks++;
      if (dqOe && !oeWin) begin
        errors++;
        $display("FAIL R11 enable outside data phase: actual=1 expected=0");
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendNib(input logic [3:0] v);
    dqDrv = v;
    waitClk(HP);
    sclk = 1'b1;
    waitClk(HP);
    sclk = 1'b0;
  endtask

  task automatic xfer(input bit sendOp, input bit quadOp, input logic [7:0] op,
                      input bit a4, input logic [31:0] addr, input logic [7:0] mode,
                      input int nBytes, input bit expData, input bit busyV,
                      input string req);
    logic [31:0] base;
    logic [7:0] b;
    int nAddr;
    quadOpMode = quadOp;
    addrMode4 = a4;
    busy = busyV;
    wrapMask = a4 ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
    base = addr & wrapMask;
    expNextAddr = base;
    reqCount = 0;
    allowReq = expData;
    nAddr = a4 ? 8 : 6;
    csN = 1'b0;
    waitClk(HP);
    if (sendOp) begin
      if (quadOp) begin
        sendNib(op[7:4]);
        sendNib(op[3:0]);
      end else begin
        for (int i = 7; i >= 0; i--) sendNib({3'b000, op[i]});
      end
    end
    for (int i = nAddr - 1; i >= 0; i--) sendNib(addr[4*i +: 4]);
    sendNib(mode[7:4]);
    sendNib(mode[3:0]);
    for (int d = 0; d < 4; d++) begin
      dqDrv = 4'h0;
      waitClk(HP);
      check("R11", {31'b0, dqOe}, 32'd0, "enable during dummy");
      sclk = 1'b1;
      waitClk(HP);
      if (d < 3) sclk = 1'b0;
    end
    oeWin = expData;
    for (int k = 0; k < nBytes; k++) begin
      b = memFn((base + k) & wrapMask);
      for (int h = 0; h < 2; h++) begin
        sclk = 1'b0;
        waitClk(HP);
        check(req, {31'b0, dqOe}, {31'b0, expData}, "output enable");
        if (expData) check(req, {28'b0, dqOut}, {28'b0, (h == 0) ? b[7:4] : b[3:0]},
                           "data nibble");
        sclk = 1'b1;
        waitClk(HP);
      end
    end
    csN = 1'b1;
    waitClk(4);
    sclk = 1'b0;
    waitClk(12);
    check("R10", {31'b0, dqOe}, 32'd0, "enable after chip-select rise");
    check(expData ? "R12" : req, reqCount, expData ? nBytes + 1 : 0, "request count");
    oeWin = 1'b0;
    allowReq = 1'b0;
    busy = 1'b0;
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      finishRun();
    end
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    check("R1", {31'b0, dqOe}, 32'd0, "enable after reset");
    check("R1", {31'b0, memReq}, 32'd0, "request after reset");

    // R2 single-line opcode, 24-bit address, invalid mode byte (R7)
    xfer(1, 0, 8'hEB, 0, 32'h0001_2345, 8'hFF, 5, 1, 0, "R2");
    // R7 opcode expected again; R5 wrap at 24-bit top; arm continuous with 0xA5
    xfer(1, 0, 8'hEB, 0, 32'h00FF_FFFE, 8'hA5, 4, 1, 0, "R5");
    // R6 no opcode, valid 0x0F keeps it armed
    xfer(0, 0, 8'h00, 0, 32'h0000_0100, 8'h0F, 3, 1, 0, "R6");
    // R6 still armed; 0x00 clears it
    xfer(0, 0, 8'h00, 0, 32'h0045_6789, 8'h00, 2, 1, 0, "R6");
    // R3 nibble opcode with R4 32-bit address wrapping at the top (R5)
    xfer(1, 1, 8'hEB, 1, 32'hFFFF_FFFF, 8'h55, 3, 1, 0, "R4");
    // R8 busy blocks the read
    xfer(1, 0, 8'hEB, 0, 32'h0000_0040, 8'h5A, 2, 0, 1, "R8");
    // R8 busy read left continuous cleared: opcode needed, and it works
    xfer(1, 0, 8'hEB, 0, 32'h0000_0080, 8'h00, 2, 1, 0, "R8");
    // R9 foreign opcode ignored
    xfer(1, 0, 8'h3B, 0, 32'h0000_0200, 8'hA5, 2, 0, 0, "R9");
    // R10 arm, then abort during address
    xfer(1, 0, 8'hEB, 0, 32'h0000_0300, 8'hF0, 2, 1, 0, "R6");
    csN = 1'b0;
    waitClk(HP);
    sendNib(4'h1);
    sendNib(4'h2);
    sendNib(4'h3);
    csN = 1'b1;
    waitClk(12);
    check("R10", {31'b0, dqOe}, 32'd0, "enable after abort");
    // R10 continuous cleared by the abort: address-first frame is taken as opcode 0x00
    xfer(0, 0, 8'h00, 0, 32'h0000_0000, 8'h00, 2, 0, 0, "R10");
    // R3 recovery with nibble opcode
    xfer(1, 1, 8'hEB, 0, 32'h0000_0010, 8'h00, 2, 1, 0, "R3");

    finished = 1'b1;
    finishRun();
  end

endmodule